// File: doc/BRIEF.md
# Serial Register-File Slave with Start-Bit Framing

This block lets a host reach a file of twelve on-chip registers over a four-wire serial link: an active-low select, a serial clock, a serial data input and a data output with an enable. A transaction starts when the first logic one appears on the data input while select is low. That one is the top bit of an 8-bit command. The command names a register and a direction. It is followed by an 8-bit or 16-bit data phase, and the addressed register sets the length. Zeros sampled before that one are idle clocks. After a complete transfer the framing goes back to searching for a start bit, so several transactions can share one select-low period.

A converter core beside the block gives a one-cycle conversion-done strobe with a 16-bit value. That value loads the read-only result register. The end-of-conversion output then stays high for a fixed number of system clocks, and the result can be read once it has fallen. All serial inputs are synchronised into the system clock domain, and their edges are found there.

Top module: `spi_rf_slave`

## Requirements
- R1: While cs_n is high, sdo_oe is 0, and clock or data activity on sclk and sdi changes no register.
- R2: sdi is sampled on a rising sclk edge and sdo changes after a falling sclk edge. Both directions shift the most significant bit first.
- R3: Zeros sampled before the first one are discarded. The first one sampled on sdi is the start bit and becomes bit 7 of the command.
- R4: Command bit 7 is the start bit. Bit 6 is the direction (0 write, 1 read), bits 5..1 select the register and bit 0 is ignored.
- R5: Registers 0–5 and 9 are 8 bits wide, and registers 6, 7, 8, 10 and 11 are 16 bits wide. The data phase lasts exactly that many clocks. Unused codes 12–31 act as 8-bit registers.
- R6: In a read, the addressed value is loaded into the output shifter on the falling edge after the last command bit, so its MSB is on sdo for the first data clock. An 8-bit value is left-justified.
- R7: Register 9 (identifier, reads 0xA5) and register 10 (result) are read-only, so writes to them are ignored. Writes to codes 12–31 are ignored, and reads of those codes return zeros.
- R8: A write takes effect only after its final data bit has been sampled. Raising cs_n at any point aborts the transaction, discards a partially shifted write and returns to start-bit search.
- R9: A conv_done pulse loads conv_data into register 10. eoc is high from the next cycle for EOC_CYCLES system clocks and then low.
- R10: If the read capture of register 10 falls in the same system clock cycle as conv_done, the read returns the value held before that update.
- R11: After a complete data phase, a new start bit begins a new transaction without cs_n being raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for sdo, 1 while selected |
| conv_done | input | 1 | One-cycle conversion-complete strobe |
| conv_data | input | 16 | Conversion value loaded on conv_done |
| eoc | output | 1 | End-of-conversion indicator |

## Verification
The two functions that can fall in the same system clock are the read capture of the result register and a result update from conv_done. The bench counts the synchroniser delay after the falling sclk edge that follows the last command bit, and pulses conv_done in exactly the cycle when the capture registers. It judges the outcome by the 16 bits shifted out, which must be the old result, and by a second read, which must return the new one with eoc raised in between.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
    localparam int NREG      = 12;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int NARROW_W  = 8;
    localparam int CNT_W     = $clog2(DATA_W + 1);
    localparam int ID_ADDR   = 9;
    localparam int RES_ADDR  = 10;

    typedef enum logic [1:0] {
        S_HUNT = 2'd0,
        S_CMD  = 2'd1,
        S_DATA = 2'd2
    } seq_state_e;

    function automatic logic reg_is_wide(input logic [ADDR_W-1:0] a);
        int unsigned i;
        i = int'(a);
        return (i == 6) || (i == 7) || (i == 8) || (i == RES_ADDR) || (i == 11);
    endfunction

    function automatic logic reg_is_writable(input logic [ADDR_W-1:0] a);
        int unsigned i;
        i = int'(a);
        return (i < NREG) && (i != ID_ADDR) && (i != RES_ADDR);
    endfunction
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_act,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdi_s
);
    typedef struct packed {
        logic [STAGES-1:0] cs_sh;
        logic [STAGES-1:0] ck_sh;
        logic [STAGES-1:0] di_sh;
        logic              ck_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d         = q;
        d.cs_sh   = {q.cs_sh[STAGES-2:0], cs_n};
        d.ck_sh   = {q.ck_sh[STAGES-2:0], sclk};
        d.di_sh   = {q.di_sh[STAGES-2:0], sdi};
        d.ck_prev = q.ck_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cs_sh: '1, ck_sh: '0, di_sh: '0, ck_prev: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign cs_act    = ~q.cs_sh[STAGES-1];
    assign sclk_rise =  q.ck_sh[STAGES-1] & ~q.ck_prev;
    assign sclk_fall = ~q.ck_sh[STAGES-1] &  q.ck_prev;
    assign sdi_s     =  q.di_sh[STAGES-1];
endmodule

// File: rtl/spi_rf_seq.sv
module spi_rf_seq
    import spi_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe
);
    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        cmd;
        logic              rd;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] sh_in;
        logic [DATA_W-1:0] sh_out;
        logic              loaded;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic              oe;
    } seq_t;

    seq_t q, d;
    logic [7:0]       cmd_full;
    logic [CNT_W-1:0] last_idx;

    assign cmd_full = {q.cmd[6:0], sdi_s};
    assign last_idx = q.wide ? CNT_W'(DATA_W - 1) : CNT_W'(NARROW_W - 1);

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        d.oe    = cs_act;
        if (!cs_act) begin
            d.state  = S_HUNT;
            d.cnt    = '0;
            d.loaded = 1'b0;
            d.sh_in  = '0;
            d.sh_out = '0;
        end else begin
            if (sclk_rise) begin
                unique case (q.state)
                    S_HUNT: begin
                        if (sdi_s) begin
                            d.cmd   = 8'h01;
                            d.cnt   = CNT_W'(1);
                            d.state = S_CMD;
                        end
                    end
                    S_CMD: begin
                        d.cmd = cmd_full;
                        if (q.cnt == CNT_W'(7)) begin
                            d.state  = S_DATA;
                            d.rd     = cmd_full[6];
                            d.addr   = cmd_full[5:1];
                            d.wide   = reg_is_wide(cmd_full[5:1]);
                            d.cnt    = '0;
                            d.loaded = 1'b0;
                            d.sh_in  = '0;
                        end else begin
                            d.cnt = q.cnt + CNT_W'(1);
                        end
                    end
                    S_DATA: begin
                        d.sh_in = {q.sh_in[DATA_W-2:0], sdi_s};
                        if (q.cnt == last_idx) begin
                            d.state = S_HUNT;
                            d.cnt   = '0;
                            if (!q.rd) begin
                                d.wr_en   = 1'b1;
                                d.wr_addr = q.addr;
                                d.wr_data = {q.sh_in[DATA_W-2:0], sdi_s};
                            end
                        end else begin
                            d.cnt = q.cnt + CNT_W'(1);
                        end
                    end
                    default: d.state = S_HUNT;
                endcase
            end
            if (sclk_fall) begin
                if (q.state == S_DATA && q.rd && !q.loaded) begin
                    d.sh_out = q.wide ? rd_data
                                      : {rd_data[NARROW_W-1:0], {(DATA_W-NARROW_W){1'b0}}};
                    d.loaded = 1'b1;
                end else begin
                    d.sh_out = {q.sh_out[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: S_HUNT, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.addr;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign sdo     = q.sh_out[DATA_W-1];
    assign sdo_oe  = q.oe;

    AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !wr_en) else $error("write while deselected"); // R8
    AST_WRITE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(sclk_rise)) else $error("write without a sampled bit"); // R8
    AST_ZERO_STAYS_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && q.state == S_HUNT && sclk_rise && !sdi_s) |=> (q.state == S_HUNT))
        else $error("zero left start-bit search"); // R3
endmodule

// File: rtl/spi_rf_regs.sv
module spi_rf_regs
    import spi_rf_pkg::*;
#(
    parameter int          EOC_CYCLES = 16,
    parameter logic [7:0]  ID_VALUE   = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              eoc
);
    localparam int EW = $clog2(EOC_CYCLES + 1);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]           result;
        logic                        eoc;
        logic [EW-1:0]               eoc_cnt;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en && reg_is_writable(wr_addr)) begin
            d.mem[wr_addr[$clog2(NREG)-1:0]] = reg_is_wide(wr_addr) ? wr_data
                : {{(DATA_W-NARROW_W){1'b0}}, wr_data[NARROW_W-1:0]};
        end
        if (conv_done) begin
            d.result  = conv_data;
            d.eoc     = 1'b1;
            d.eoc_cnt = EW'(EOC_CYCLES - 1);
        end else if (q.eoc) begin
            if (q.eoc_cnt == '0) begin
                d.eoc = 1'b0;
            end else begin
                d.eoc_cnt = q.eoc_cnt - EW'(1);
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) == ID_ADDR) begin
            rd_data = {{(DATA_W-NARROW_W){1'b0}}, ID_VALUE};
        end else if (int'(rd_addr) == RES_ADDR) begin
            rd_data = q.result;
        end else if (reg_is_writable(rd_addr)) begin
            rd_data = q.mem[rd_addr[$clog2(NREG)-1:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign eoc = q.eoc;

    AST_RESULT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(q.result)) else $error("result changed without conversion"); // R7
    AST_EOC_ON_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> eoc) else $error("eoc not raised"); // R9
endmodule

// File: rtl/spi_rf_slave.sv
module spi_rf_slave
    import spi_rf_pkg::*;
#(
    parameter int         EOC_CYCLES  = 16,
    parameter logic [7:0] ID_VALUE    = 8'hA5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              eoc
);
    logic              cs_act, sclk_rise, sclk_fall, sdi_s;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;

    spi_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s)
    );

    spi_rf_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .sdi_s(sdi_s), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    spi_rf_regs #(.EOC_CYCLES(EOC_CYCLES), .ID_VALUE(ID_VALUE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .conv_done(conv_done),
        .conv_data(conv_data), .eoc(eoc)
    );

    AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdo_oe) else $error("sdo enabled while deselected"); // R1
endmodule

// File: tb/tb_spi_rf_slave.sv
module tb_spi_rf_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int EOC_HOLD   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo, sdo_oe, eoc;
    logic        conv_done = 1'b0;
    logic [15:0] conv_data = '0;

    int n_run  = 0;
    int n_fail = 0;
    logic [15:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_rf_slave #(.EOC_CYCLES(EOC_HOLD), .ID_VALUE(8'hA5)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .conv_done(conv_done), .conv_data(conv_data), .eoc(eoc)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin();
        sclk = 1'b0;
        cs_n = 1'b0;
        wait_clk(HALF);
        chk("R1 oe on when selected", {15'd0, sdo_oe}, 16'd1);
    endtask

    task automatic cs_end();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(5);
    endtask

    // lz leading zeros, command byte, nd data bits; hook pulses conv_done at read capture
    task automatic xfer(input int lz, input logic [7:0] cmd, input int nd,
                        input logic [15:0] wd, input bit hook, output logic [15:0] rd);
        rd = '0;
        for (int k = 0; k < lz + 8 + nd; k++) begin
            logic b;
            if (k < lz) b = 1'b0;
            else if (k < lz + 8) b = cmd[7 - (k - lz)];
            else b = wd[nd - 1 - (k - lz - 8)];
            sdi = b;
            if (hook && k == lz + 8) begin
                wait_clk(2);
                conv_done = 1'b1;
                wait_clk(1);
                conv_done = 1'b0;
                wait_clk(HALF - 3);
            end else begin
                wait_clk(HALF);
            end
            if (k >= lz + 8) rd = {rd[14:0], sdo};
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        sdi = 1'b0;
    endtask

    function automatic logic [7:0] mk_cmd(input bit rd, input int addr);
        return {1'b1, rd, 5'(addr), 1'b0};
    endfunction

    task automatic wr_reg(input int addr, input int nd, input logic [15:0] wd, input int lz);
        logic [15:0] dummy;
        cs_begin();
        xfer(lz, mk_cmd(1'b0, addr), nd, wd, 1'b0, dummy);
        cs_end();
    endtask

    task automatic rd_reg(input int addr, input int nd, output logic [15:0] r);
        cs_begin();
        xfer(0, mk_cmd(1'b1, addr), nd, 16'h0, 1'b0, r);
        cs_end();
    endtask

    task automatic t_reset();
        chk("R1 reset oe", {15'd0, sdo_oe}, 16'd0);
        chk("R9 reset eoc", {15'd0, eoc}, 16'd0);
        rd_reg(0, 8, rv);
        chk("R5 reset value reg0", rv, 16'h0000);
    endtask

    task automatic t_narrow();
        wr_reg(2, 8, 16'h003C, 3);
        rd_reg(2, 8, rv);
        chk("R3 R4 leading zeros then write reg2", rv, 16'h003C);
        wr_reg(4, 8, 16'h00C3, 0);
        rd_reg(4, 8, rv);
        chk("R2 R6 msb-first narrow read reg4", rv, 16'h00C3);
        rd_reg(2, 8, rv);
        chk("R5 reg2 kept", rv, 16'h003C);
    endtask

    task automatic t_wide();
        wr_reg(7, 16, 16'hBEEF, 1);
        rd_reg(7, 16, rv);
        chk("R5 wide reg7", rv, 16'hBEEF);
        wr_reg(11, 16, 16'h8001, 0);
        rd_reg(11, 16, rv);
        chk("R5 wide reg11", rv, 16'h8001);
    endtask

    task automatic t_readonly();
        wr_reg(9, 8, 16'h0000, 0);
        rd_reg(9, 8, rv);
        chk("R7 id read-only", rv, 16'h00A5);
        wr_reg(20, 8, 16'h00FF, 0);
        rd_reg(20, 8, rv);
        chk("R7 unused code reads zero", rv, 16'h0000);
        wr_reg(10, 16, 16'hFFFF, 0);
        rd_reg(10, 16, rv);
        chk("R7 result ignores write", rv, 16'h1234);
    endtask

    task automatic t_abort();
        logic [15:0] dummy;
        wr_reg(3, 8, 16'h005A, 0);
        cs_begin();
        xfer(0, mk_cmd(1'b0, 3), 4, 16'h000F, 1'b0, dummy);
        cs_end();
        rd_reg(3, 8, rv);
        chk("R8 aborted write discarded", rv, 16'h005A);
    endtask

    task automatic t_deselected();
        cs_n = 1'b1;
        sdi  = 1'b1;
        for (int k = 0; k < 20; k++) begin
            sclk = ~sclk;
            wait_clk(HALF);
            if (sdo_oe !== 1'b0) chk("R1 oe while deselected", {15'd0, sdo_oe}, 16'd0);
        end
        sclk = 1'b0;
        sdi  = 1'b0;
        wait_clk(4);
        chk("R1 oe off after toggling", {15'd0, sdo_oe}, 16'd0);
        rd_reg(2, 8, rv);
        chk("R1 reg2 untouched", rv, 16'h003C);
    endtask

    task automatic t_back_to_back();
        logic [15:0] dummy;
        cs_begin();
        xfer(2, mk_cmd(1'b0, 0), 8, 16'h0081, 1'b0, dummy);
        xfer(0, mk_cmd(1'b1, 0), 8, 16'h0000, 1'b0, rv);
        cs_end();
        chk("R11 second transaction same select", rv, 16'h0081);
    endtask

    task automatic t_conv();
        conv_data = 16'h1234;
        conv_done = 1'b1;
        wait_clk(1);
        conv_done = 1'b0;
        chk("R9 eoc high after strobe", {15'd0, eoc}, 16'd1);
        wait_clk(EOC_HOLD - 1);
        chk("R9 eoc still high at end", {15'd0, eoc}, 16'd1);
        wait_clk(1);
        chk("R9 eoc low after hold", {15'd0, eoc}, 16'd0);
        rd_reg(10, 16, rv);
        chk("R9 result loaded", rv, 16'h1234);
    endtask

    task automatic t_collide();
        conv_data = 16'hABCD;
        cs_begin();
        xfer(0, mk_cmd(1'b1, 10), 16, 16'h0000, 1'b1, rv);
        cs_end();
        chk("R10 capture returns old result", rv, 16'h1234);
        rd_reg(10, 16, rv);
        chk("R10 new result afterwards", rv, 16'hABCD);
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_narrow();
        t_wide();
        t_conv();
        t_readonly();
        t_abort();
        t_deselected();
        t_back_to_back();
        t_collide();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule